// File: doc/BRIEF.md
# HDLC Receive Buffer with Host Pools

This block sits between an HDLC deframer and a host. The deframer hands over payload bytes one at a time and, at the end of each frame, a four-bit verdict (frame valid, data overflow, checksum correct, frame aborted). The block turns that verdict into a status byte, stores it behind the payload as the last byte of the frame, and keeps everything in a store made of two equal pools of `POOL_BYTES` bytes each.

A pool goes to the host once it is full, which raises the pool-ready interrupt bit, or once a frame ends in it, which raises the frame-end bit and latches the frame length and status byte. The host reads the bytes of the pool it holds one by one and then frees the pool with a release command. While the host holds one pool, the deframer fills the other. If a byte arrives and both pools are held, the overflow bit is raised and reception stops until the host issues the receiver reset command.

The length register holds the whole frame length, status byte included. The host keeps only the low bits, which give the size of the final pool. A masked value of zero means that final pool is full.

Top module: `hdlc_rx_pool`

## Requirements
- R1: After reset, `int_stat`, `irq`, `byte_cnt` and `rx_stat` are all zero.
- R2: When a pool holds `POOL_BYTES` bytes without a frame end, bit 0x40 of `int_stat` is set, and `rd_data` returns those bytes in arrival order, one per `rd_en` pulse.
- R3: A frame end sets bit 0x80 of `int_stat` when its pool is handed over. The status byte is `{in_stat, 4'b0000}`, where `in_stat` bit 3 is frame valid, bit 2 is data overflow, bit 1 is checksum correct and bit 0 is aborted. It is read through `rd_data` as the byte after the last payload byte.
- R4: At frame-end hand-over, `byte_cnt` equals the number of payload bytes plus one. A 63-byte payload gives 64, whose low five bits are 0, meaning a full final pool.
- R5: At frame-end hand-over, `rx_stat` equals the status byte. A good frame (valid, no overflow, checksum correct, not aborted) gives upper nibble 0xA, and a flawed frame gives a different upper nibble.
- R6: A `cmd_wr` with `cmd` = 0x80 frees the held pool, restarts the read position and hands over the next waiting pool. The same command with no pool handed over has no effect.
- R7: While the host holds one pool, arriving bytes fill the other pool. A second completed pool raises no interrupt and changes neither `byte_cnt` nor `rx_stat` until the first pool is released.
- R8: A byte or frame end that arrives while both pools are held sets bit 0x20 of `int_stat` and is discarded, and so is everything after it until a receiver reset.
- R9: A `cmd_wr` with `cmd` = 0x40 empties both pools and ends the discard. The next frame is then received and handed over normally. Interrupt bits are kept.
- R10: `int_clr` clears, one for one, the `int_stat` bits that are set in it. `irq` is the OR of the `int_stat` bits. Command codes other than 0x80 and 0x40 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Payload byte strobe from the deframer |
| in_data | input | 8 | Payload byte |
| in_end | input | 1 | End-of-frame strobe, exclusive with `in_valid` |
| in_stat | input | 4 | Frame verdict {valid, overflow, checksum ok, aborted}, read with `in_end` |
| rd_en | input | 1 | Host consumes the byte shown on `rd_data` |
| rd_data | output | 8 | Byte at the read position of the held pool |
| cmd_wr | input | 1 | Command strobe |
| cmd | input | 8 | Command code: 0x80 release, 0x40 receiver reset |
| int_clr | input | 8 | Write-one-to-clear mask for `int_stat` |
| int_stat | output | 8 | Sticky interrupt bits: 0x80 frame end, 0x40 pool ready, 0x20 overflow |
| irq | output | 1 | Interrupt request |
| byte_cnt | output | LEN_W | Full length of the last handed-over frame, status byte included |
| rx_stat | output | 8 | Status byte of the last handed-over frame |

## Verification
A byte or frame end sampled at one rising edge completes its pool at that edge. The interrupt bit, `byte_cnt` and `rx_stat` follow at the next rising edge, so results are due two edges after the stimulus. A release takes one edge to free the pool and one more to hand over a waiting pool. `rd_data` follows the read position with no added register. The bench drives inputs and samples outputs on the falling edge, and waits two full cycles after every stimulus before it compares, so every check falls after the latest edge at which the result can change.

// File: rtl/hdlc_rx_pool.sv
module hdlc_rx_pool #(
  parameter int POOL_BYTES = 32,
  parameter int LEN_W      = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_end,
  input  logic [3:0]       in_stat,
  input  logic             rd_en,
  output logic [7:0]       rd_data,
  input  logic             cmd_wr,
  input  logic [7:0]       cmd,
  input  logic [7:0]       int_clr,
  output logic [7:0]       int_stat,
  output logic             irq,
  output logic [LEN_W-1:0] byte_cnt,
  output logic [7:0]       rx_stat
);
  localparam int AW = $clog2(POOL_BYTES);
  localparam logic [7:0] CMD_REL = 8'h80;
  localparam logic [7:0] CMD_RST = 8'h40;

  typedef enum logic [1:0] {P_FREE, P_FILL, P_HELD} pool_t;

  logic [7:0]       mem [2*POOL_BYTES];
  pool_t            pst [2];
  logic             fin [2];
  logic [LEN_W-1:0] mlen [2];
  logic [7:0]       mstat [2];
  logic             wr_h, hd_h, pres, drop;
  logic [AW-1:0]    wr_cnt, rd_ptr;
  logic [LEN_W-1:0] frm_len;

  wire       do_rel    = cmd_wr && (cmd == CMD_REL);
  wire       do_rst    = cmd_wr && (cmd == CMD_RST);
  wire [7:0] stat_byte = {in_stat, 4'b0000};
  wire       in_take   = (in_valid || in_end) && !drop && !do_rst;
  wire       can_wr    = (pst[wr_h] != P_HELD);
  wire       wr_fire   = in_take && can_wr;
  wire       ovf_ev    = in_take && !can_wr;
  wire       pool_done = wr_fire && (in_end || (wr_cnt == AW'(POOL_BYTES-1)));
  wire       rel_go    = do_rel && pres;
  wire       present   = !pres && (pst[hd_h] == P_HELD) && !do_rst;
  wire [7:0] wbyte     = in_end ? stat_byte : in_data;

  assign rd_data = mem[{hd_h, rd_ptr}];
  assign irq     = |int_stat;

  always_ff @(posedge clk) begin
    if (wr_fire) mem[{wr_h, wr_cnt}] <= wbyte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        pst[i]   <= P_FREE;
        fin[i]   <= 1'b0;
        mlen[i]  <= '0;
        mstat[i] <= '0;
      end
      wr_h     <= 1'b0;
      hd_h     <= 1'b0;
      pres     <= 1'b0;
      drop     <= 1'b0;
      wr_cnt   <= '0;
      rd_ptr   <= '0;
      frm_len  <= '0;
      byte_cnt <= '0;
      rx_stat  <= '0;
    end else if (do_rst) begin
      for (int i = 0; i < 2; i++) pst[i] <= P_FREE;
      wr_h    <= 1'b0;
      hd_h    <= 1'b0;
      pres    <= 1'b0;
      drop    <= 1'b0;
      wr_cnt  <= '0;
      rd_ptr  <= '0;
      frm_len <= '0;
    end else begin
      if (wr_fire) begin
        pst[wr_h] <= pool_done ? P_HELD : P_FILL;
        wr_cnt    <= pool_done ? '0 : wr_cnt + 1'b1;
        if (pool_done) wr_h <= ~wr_h;
        if (in_end) begin
          fin[wr_h]   <= 1'b1;
          mlen[wr_h]  <= frm_len + 1'b1;
          mstat[wr_h] <= stat_byte;
          frm_len     <= '0;
        end else begin
          frm_len <= frm_len + 1'b1;
          if (pool_done) fin[wr_h] <= 1'b0;
        end
      end
      if (ovf_ev) drop <= 1'b1;
      if (rel_go) begin
        pst[hd_h] <= P_FREE;
        hd_h      <= ~hd_h;
        pres      <= 1'b0;
        rd_ptr    <= '0;
      end else if (rd_en && pres) begin
        rd_ptr <= rd_ptr + 1'b1;
      end
      if (present) begin
        pres <= 1'b1;
        if (fin[hd_h]) begin
          byte_cnt <= mlen[hd_h];
          rx_stat  <= mstat[hd_h];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) int_stat <= '0;
    else int_stat <= (int_stat & ~int_clr)
                   | {present && fin[hd_h], present && !fin[hd_h], ovf_ev, 5'b00000};
  end

  AST_FRAME_END_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pres) && fin[hd_h]) |-> int_stat[7]);  // R3
  AST_POOL_READY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pres) && !fin[hd_h]) |-> int_stat[6]);  // R2
  AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd == CMD_REL && pres) |=> (pst[$past(hd_h)] == P_FREE));  // R6
  AST_HELD_INFO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pres && $past(pres)) |-> ($stable(byte_cnt) && $stable(rx_stat)));  // R7
  AST_OVERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drop) |-> int_stat[5]);  // R8
  AST_RESET_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd == CMD_RST) |=> (!pres && !drop && pst[0] == P_FREE && pst[1] == P_FREE));  // R9
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (int_stat != 8'h00));  // R10
endmodule

// File: tb/hdlc_rx_pool_bench.sv
module hdlc_rx_pool_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_end = 1'b0, rd_en = 1'b0, cmd_wr = 1'b0;
  logic [7:0]  in_data = '0, cmd = '0, int_clr = '0;
  logic [3:0]  in_stat = '0;
  logic [7:0]  rd_data, int_stat, rx_stat;
  logic        irq;
  logic [11:0] byte_cnt;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_rx_pool u_hdlc_rx_pool (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_end(in_end), .in_stat(in_stat), .rd_en(rd_en), .rd_data(rd_data),
    .cmd_wr(cmd_wr), .cmd(cmd), .int_clr(int_clr), .int_stat(int_stat),
    .irq(irq), .byte_cnt(byte_cnt), .rx_stat(rx_stat));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic settle(); repeat (2) @(negedge clk); endtask

  task automatic send_byte(input logic [7:0] b);
    in_valid = 1'b1; in_data = b; @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic send_end(input logic [3:0] s);
    in_end = 1'b1; in_stat = s; @(negedge clk); in_end = 1'b0;
  endtask

  task automatic host_cmd(input logic [7:0] c);
    cmd_wr = 1'b1; cmd = c; @(negedge clk); cmd_wr = 1'b0; settle();
  endtask

  task automatic clr_ints(input logic [7:0] m);
    int_clr = m; @(negedge clk); int_clr = '0; settle();
  endtask

  task automatic read_expect(input string req, input logic [7:0] exp);
    chk(req, rd_data, exp);
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 int_stat", int_stat, 0);
    chk("R1 irq", irq, 0);
    chk("R1 byte_cnt", byte_cnt, 0);
    chk("R1 rx_stat", rx_stat, 0);
  endtask

  task automatic t_short_frame();
    for (int i = 0; i < 5; i++) send_byte(8'hA0 + 8'(i));
    send_end(4'b1010);
    settle();
    chk("R3 frame end bit", int_stat, 8'h80);
    chk("R10 irq set", irq, 1);
    chk("R4 short length", byte_cnt, 6);
    chk("R5 good status", rx_stat, 8'hA0);
    for (int i = 0; i < 5; i++) read_expect("R3 payload", 8'hA0 + 8'(i));
    read_expect("R3 status byte last", 8'hA0);
    clr_ints(8'h80);
    chk("R10 cleared", int_stat, 0);
    chk("R10 irq clear", irq, 0);
    host_cmd(8'h80);
  endtask

  task automatic t_long_frame();
    for (int i = 0; i < 63; i++) send_byte(8'h10 + 8'(i));
    send_end(4'b1010);
    settle();
    chk("R2 pool ready only", int_stat, 8'h40);
    for (int i = 0; i < 32; i++) read_expect("R2 first pool", 8'h10 + 8'(i));
    clr_ints(8'h40);
    host_cmd(8'h80);
    chk("R6 next pool handed", int_stat, 8'h80);
    chk("R4 full length", byte_cnt, 64);
    chk("R4 masked zero", byte_cnt & 12'h01F, 0);
    for (int i = 32; i < 63; i++) read_expect("R6 read restarts", 8'h10 + 8'(i));
    read_expect("R3 status after payload", 8'hA0);
    clr_ints(8'hFF);
    host_cmd(8'h80);
  endtask

  task automatic t_bad_status();
    send_byte(8'h33);
    send_end(4'b1001);
    settle();
    chk("R5 flawed status", rx_stat, 8'h90);
    chk("R5 nibble not A", rx_stat[7:4] != 4'hA, 1);
    chk("R4 length", byte_cnt, 2);
    clr_ints(8'hFF);
    host_cmd(8'h80);
  endtask

  task automatic t_two_pools();
    send_byte(8'hC1); send_byte(8'hC2); send_byte(8'hC3); send_end(4'b1010);
    settle();
    clr_ints(8'h80);
    send_byte(8'hD1); send_byte(8'hD2); send_end(4'b1110);
    settle();
    chk("R7 no new interrupt", int_stat, 0);
    chk("R7 length kept", byte_cnt, 4);
    chk("R7 status kept", rx_stat, 8'hA0);
    read_expect("R7 first pool data", 8'hC1);
    host_cmd(8'h80);
    chk("R6 waiting pool handed", int_stat, 8'h80);
    chk("R6 second length", byte_cnt, 3);
    chk("R6 second status", rx_stat, 8'hE0);
    read_expect("R7 second pool data", 8'hD1);
    read_expect("R7 second pool data", 8'hD2);
    clr_ints(8'hFF);
    host_cmd(8'h80);
  endtask

  task automatic t_overflow();
    send_byte(8'h41); send_byte(8'h42); send_end(4'b1010);
    send_byte(8'h51); send_byte(8'h52); send_end(4'b1010);
    settle();
    send_byte(8'h61);
    settle();
    chk("R8 overflow bit", int_stat & 8'h20, 8'h20);
    chk("R8 held frame kept", rx_stat, 8'hA0);
    read_expect("R8 held data intact", 8'h41);
    send_end(4'b1010);
    settle();
    chk("R8 later end ignored", byte_cnt, 3);
    host_cmd(8'h40);
    chk("R9 interrupt bits kept", int_stat & 8'h20, 8'h20);
    clr_ints(8'hFF);
    send_byte(8'h5A); send_byte(8'h5B); send_end(4'b1011);
    settle();
    chk("R9 frame after reset", int_stat, 8'h80);
    chk("R9 length", byte_cnt, 3);
    chk("R9 status", rx_stat, 8'hB0);
    read_expect("R9 data", 8'h5A);
    clr_ints(8'hFF);
    host_cmd(8'h80);
  endtask

  task automatic t_ignored_cmds();
    host_cmd(8'h80);
    chk("R6 idle release no effect", int_stat, 0);
    send_byte(8'h77); send_byte(8'h78); send_end(4'b1000);
    settle();
    chk("R6 frame after idle release", int_stat, 8'h80);
    chk("R5 status valid only", rx_stat, 8'h80);
    read_expect("R10 data", 8'h77);
    host_cmd(8'h11);
    chk("R10 unknown cmd keeps pool", rd_data, 8'h78);
    chk("R10 unknown cmd keeps int", int_stat, 8'h80);
    host_cmd(8'h80);
    clr_ints(8'hFF);
    send_byte(8'h99); send_end(4'b1010);
    settle();
    chk("R6 after release", byte_cnt, 2);
    read_expect("R6 new data", 8'h99);
    clr_ints(8'hFF);
    host_cmd(8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    settle();
    t_short_frame();
    t_long_frame();
    t_bad_status();
    t_two_pools();
    t_overflow();
    t_ignored_cmds();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule